// File: doc/BRIEF.md
# Shared Scaler Pool Allocator

This control block hands out a small pool of scaler engines (one or two per display pipe) to the users that need them. A user is one of up to 31 planes or the pipe itself. By convention the pipe-level user takes the highest index. Software-side staging is modelled as a one-cycle staging port. Each staging call names a user and gives its source and destination sizes plus a few format and mode flags. The block decides whether the user needs a scaler and checks the sizes against the legal window. It then either adds the user to a pending users mask, removes it from the mask, or rejects the call.

A commit strobe starts a small state machine. It first rejects the whole commit if more users are pending than the pool has scalers. It then visits one user bit per cycle, from bit 0 upward, and binds each pending user that has no scaler yet to the lowest-numbered free one. It applies a preference rule and per-scaler scaling limits along the way. A commit ends with a one-cycle done or error pulse. On error, the pool state is put back exactly as it was before the commit.

The outputs are, per user, a valid flag and a scaler index. Per scaler, the outputs are an in-use flag and a mode bit.

Top module: `scl_pool_top`

## Requirements
- R1: After reset no user holds a grant, every scaler is free, every mode bit is 0, and done, error and staging-error outputs are low.
- R2: A staged user needs a scaler when its source width or height differs from its destination, or when `need_i` is set. A staged user that needs none is treated like a release and gets no grant at the next commit.
- R3: A release (or a no-need staging) removes the user from the pending mask. It also drops its grant and frees its scaler at the staging edge, so both are visible in the next cycle.
- R4: A needing request is rejected with a `stage_err_o` pulse and leaves the mask unchanged in either of these cases: a dimension is below 8, the source is below 16 in either dimension when `semi_i` marks a semiplanar YUV source, or any dimension exceeds the 4096 maximum.
- R5: A needing request made while `interlace_i` is high is rejected with `stage_err_o`.
- R6: A commit whose pending-user count exceeds the number of scalers ends in an error pulse and changes no grant.
- R7: Assignment walks user bits from 0 upward. A pending user without a grant receives the lowest-numbered free scaler, and a user already holding a scaler keeps it.
- R8: When exactly one user is pending and the pool has two scalers, that user is moved to scaler 0 and `mode_o[0]` is set to 1 (high-quality). Otherwise each assigned scaler gets mode 0 (dynamic).
- R9: A commit fails if a pending user's source width or height is 3 or more times its destination value. A ratio just below 3 is accepted.
- R10: With `VLIMIT_EN` set, a user bound to any scaler other than 0 whose source height exceeds its destination height fails the commit. On scaler 0 the same user is accepted.
- R11: When a commit fails, in-use flags, grants and mode bits return to their values from before the commit, including changes made earlier in the same walk.
- R12: Staging calls arriving while a commit is in progress are ignored.
- R13: Each accepted commit produces exactly one single-cycle pulse on either `done_o` or `err_o`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stage_i | input | 1 | Staging call strobe |
| stage_user_i | input | UW | User index of the staging call |
| release_i | input | 1 | Drop the user's claim |
| need_i | input | 1 | Explicit scaler request |
| semi_i | input | 1 | Source is semiplanar YUV |
| interlace_i | input | 1 | Display mode is interlaced |
| src_w_i | input | DW | Source width |
| src_h_i | input | DW | Source height |
| dst_w_i | input | DW | Destination width |
| dst_h_i | input | DW | Destination height |
| commit_i | input | 1 | Start assignment |
| stage_err_o | output | 1 | Staging call rejected (one cycle) |
| busy_o | output | 1 | Commit in progress |
| done_o | output | 1 | Commit succeeded (one cycle) |
| err_o | output | 1 | Commit failed (one cycle) |
| grant_vld_o | output | NUM_USERS | User holds a scaler |
| grant_id_o | output | NUM_USERS*IDW | Scaler index per user, packed by user |
| in_use_o | output | NUM_SCALERS | Scaler is bound |
| mode_o | output | NUM_SCALERS | 1 = high-quality, 0 = dynamic |

## Verification
The bench instantiates the block with 8 users, two scalers and `VLIMIT_EN` set. The two-scaler pool is needed to reach the move onto scaler 0 with high-quality mode, the lowest-free choice between two candidates, and over-subscription with a third user. With the vertical limit enabled, a commit can fail on scaler 1 yet succeed on scaler 0. The small user count keeps each commit walk short, which leaves room to fail a commit after an earlier user was already bound and so test the full rollback.

// File: rtl/scl_pool_pkg.sv
package scl_pool_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ASSIGN,
    ST_DONE,
    ST_ERROR
  } state_e;

  localparam logic MODE_DYN = 1'b0;
  localparam logic MODE_HQ  = 1'b1;
endpackage

// File: rtl/scl_size_check.sv
module scl_size_check #(
  parameter int DW           = 14,
  parameter int MIN_DIM      = 8,
  parameter int MIN_DIM_SEMI = 16,
  parameter int MAX_SRC_W    = 4096,
  parameter int MAX_SRC_H    = 4096,
  parameter int MAX_DST_W    = 4096,
  parameter int MAX_DST_H    = 4096
) (
  input  logic [DW-1:0] src_w_i,
  input  logic [DW-1:0] src_h_i,
  input  logic [DW-1:0] dst_w_i,
  input  logic [DW-1:0] dst_h_i,
  input  logic          semi_i,
  output logic          differ_o,
  output logic          in_range_o,
  output logic          hbad_o,
  output logic          vbad_o,
  output logic          vdown_o
);
  localparam logic [DW-1:0] MinL   = DW'(MIN_DIM);
  localparam logic [DW-1:0] MinSL  = DW'(MIN_DIM_SEMI);
  localparam logic [DW-1:0] MaxSwL = DW'(MAX_SRC_W);
  localparam logic [DW-1:0] MaxShL = DW'(MAX_SRC_H);
  localparam logic [DW-1:0] MaxDwL = DW'(MAX_DST_W);
  localparam logic [DW-1:0] MaxDhL = DW'(MAX_DST_H);

  logic [DW-1:0] src_min;
  logic [DW+1:0] dst_w3, dst_h3;

  assign src_min  = semi_i ? MinSL : MinL;
  assign differ_o = (src_w_i != dst_w_i) || (src_h_i != dst_h_i);

  assign in_range_o = (src_w_i >= src_min) && (src_h_i >= src_min) &&
                      (dst_w_i >= MinL)    && (dst_h_i >= MinL)    &&
                      (src_w_i <= MaxSwL)  && (src_h_i <= MaxShL)  &&
                      (dst_w_i <= MaxDwL)  && (dst_h_i <= MaxDhL);

  // ratio must stay strictly below 3.0
  assign dst_w3  = {2'b00, dst_w_i} * (DW+2)'(3);
  assign dst_h3  = {2'b00, dst_h_i} * (DW+2)'(3);
  assign hbad_o  = {2'b00, src_w_i} >= dst_w3;
  assign vbad_o  = {2'b00, src_h_i} >= dst_h3;
  assign vdown_o = src_h_i > dst_h_i;
endmodule

// File: rtl/scl_first_free.sv
module scl_first_free #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic [N-1:0]  busy_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/scl_popcnt.sv
module scl_popcnt #(
  parameter int N  = 32,
  parameter int CW = 6
) (
  input  logic [N-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/scl_pool_top.sv
module scl_pool_top
  import scl_pool_pkg::*;
#(
  parameter int NUM_USERS    = 32,
  parameter int NUM_SCALERS  = 2,
  parameter int DW           = 14,
  parameter int MIN_DIM      = 8,
  parameter int MIN_DIM_SEMI = 16,
  parameter int MAX_SRC_W    = 4096,
  parameter int MAX_SRC_H    = 4096,
  parameter int MAX_DST_W    = 4096,
  parameter int MAX_DST_H    = 4096,
  parameter bit VLIMIT_EN    = 1'b0,
  localparam int UW  = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1,
  localparam int IDW = (NUM_SCALERS > 1) ? $clog2(NUM_SCALERS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     stage_i,
  input  logic [UW-1:0]            stage_user_i,
  input  logic                     release_i,
  input  logic                     need_i,
  input  logic                     semi_i,
  input  logic                     interlace_i,
  input  logic [DW-1:0]            src_w_i,
  input  logic [DW-1:0]            src_h_i,
  input  logic [DW-1:0]            dst_w_i,
  input  logic [DW-1:0]            dst_h_i,
  input  logic                     commit_i,
  output logic                     stage_err_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     err_o,
  output logic [NUM_USERS-1:0]     grant_vld_o,
  output logic [NUM_USERS*IDW-1:0] grant_id_o,
  output logic [NUM_SCALERS-1:0]   in_use_o,
  output logic [NUM_SCALERS-1:0]   mode_o
);
  localparam int CW = $clog2(NUM_USERS + 1);
  localparam logic [UW-1:0] LastUser = UW'(NUM_USERS - 1);

  state_e                 state_q;
  logic [UW-1:0]          idx_q;
  logic [NUM_USERS-1:0]   users_q, gv_q, hbad_q, vbad_q, vdown_q;
  logic [IDW-1:0]         gid_q [NUM_USERS];
  logic [NUM_SCALERS-1:0] in_use_q, mode_q;
  logic                   stage_err_q;

  // pre-commit snapshot for rollback
  logic [NUM_USERS-1:0]   snap_gv;
  logic [IDW-1:0]         snap_gid [NUM_USERS];
  logic [NUM_SCALERS-1:0] snap_in_use, snap_mode;

  // staging decode
  logic differ, in_range, hbad, vbad, vdown, need, st_fire;
  logic st_reject, st_drop, st_add;

  scl_size_check #(
    .DW(DW), .MIN_DIM(MIN_DIM), .MIN_DIM_SEMI(MIN_DIM_SEMI),
    .MAX_SRC_W(MAX_SRC_W), .MAX_SRC_H(MAX_SRC_H),
    .MAX_DST_W(MAX_DST_W), .MAX_DST_H(MAX_DST_H)
  ) u_size (
    .src_w_i(src_w_i), .src_h_i(src_h_i), .dst_w_i(dst_w_i), .dst_h_i(dst_h_i),
    .semi_i(semi_i), .differ_o(differ), .in_range_o(in_range),
    .hbad_o(hbad), .vbad_o(vbad), .vdown_o(vdown)
  );

  assign need      = need_i | differ;
  assign st_fire   = stage_i && (state_q == ST_IDLE) && !commit_i;
  assign st_reject = st_fire && need && (interlace_i || (!release_i && !in_range));
  assign st_drop   = st_fire && !st_reject && (release_i || !need);
  assign st_add    = st_fire && !st_reject && !st_drop;

  // assignment step
  logic [CW-1:0]  cnt;
  logic           ff_found;
  logic [IDW-1:0] ff_idx, pre_id, fin_id;
  logic           pre_ok, single, lim_bad, step_act, step_err;

  scl_popcnt #(.N(NUM_USERS), .CW(CW)) u_cnt (.vec_i(users_q), .cnt_o(cnt));

  scl_first_free #(.N(NUM_SCALERS), .IW(IDW)) u_ff (
    .busy_i(in_use_q), .found_o(ff_found), .idx_o(ff_idx)
  );

  assign step_act = (state_q == ST_ASSIGN) && users_q[idx_q];
  assign pre_id   = gv_q[idx_q] ? gid_q[idx_q] : ff_idx;
  assign pre_ok   = gv_q[idx_q] | ff_found;
  assign single   = (cnt == CW'(1)) && (NUM_SCALERS > 1);
  assign fin_id   = single ? '0 : pre_id;
  assign lim_bad  = hbad_q[idx_q] | vbad_q[idx_q] |
                    (VLIMIT_EN && (fin_id != '0) && vdown_q[idx_q]);
  assign step_err = step_act && (!pre_ok || lim_bad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      users_q     <= '0;
      gv_q        <= '0;
      hbad_q      <= '0;
      vbad_q      <= '0;
      vdown_q     <= '0;
      in_use_q    <= '0;
      mode_q      <= '0;
      stage_err_q <= 1'b0;
      snap_gv     <= '0;
      snap_in_use <= '0;
      snap_mode   <= '0;
      for (int u = 0; u < NUM_USERS; u++) begin
        gid_q[u]    <= '0;
        snap_gid[u] <= '0;
      end
    end else begin
      stage_err_q <= st_reject;
      if (st_drop) begin
        users_q[stage_user_i] <= 1'b0;
        gv_q[stage_user_i]    <= 1'b0;
        if (gv_q[stage_user_i]) in_use_q[gid_q[stage_user_i]] <= 1'b0;
      end
      if (st_add) begin
        users_q[stage_user_i] <= 1'b1;
        hbad_q[stage_user_i]  <= hbad;
        vbad_q[stage_user_i]  <= vbad;
        vdown_q[stage_user_i] <= vdown;
      end

      unique case (state_q)
        ST_IDLE: begin
          if (commit_i) begin
            state_q     <= ST_CHECK;
            snap_gv     <= gv_q;
            snap_gid    <= gid_q;
            snap_in_use <= in_use_q;
            snap_mode   <= mode_q;
          end
        end
        ST_CHECK: begin
          idx_q   <= '0;
          state_q <= (32'(cnt) > NUM_SCALERS) ? ST_ERROR : ST_ASSIGN;
        end
        ST_ASSIGN: begin
          if (step_err) begin
            state_q  <= ST_ERROR;
            gv_q     <= snap_gv;
            gid_q    <= snap_gid;
            in_use_q <= snap_in_use;
            mode_q   <= snap_mode;
          end else begin
            if (step_act) begin
              in_use_q[pre_id] <= 1'b0;
              in_use_q[fin_id] <= 1'b1;
              gid_q[idx_q]     <= fin_id;
              gv_q[idx_q]      <= 1'b1;
              mode_q[fin_id]   <= single ? MODE_HQ : MODE_DYN;
            end
            if (idx_q == LastUser) state_q <= ST_DONE;
            else idx_q <= idx_q + UW'(1);
          end
        end
        ST_DONE:  state_q <= ST_IDLE;
        ST_ERROR: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign stage_err_o = stage_err_q;
  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = state_q == ST_DONE;
  assign err_o       = state_q == ST_ERROR;
  assign grant_vld_o = gv_q;
  assign in_use_o    = in_use_q;
  assign mode_o      = mode_q;

  for (genvar g = 0; g < NUM_USERS; g++) begin : g_out
    assign grant_id_o[g*IDW +: IDW] = gid_q[g];

    // R7: a granted user always points at a bound scaler
    p_grant_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gv_q[g] |-> in_use_q[gid_q[g]]);
  end

  p_one_outcome_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  p_overcount_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK && 32'(cnt) > NUM_SCALERS) |=> err_o);

  p_reject_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_err_o |-> users_q == $past(users_q));

  p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_fire && release_i && !st_reject) |=> !gv_q[$past(stage_user_i)]);

  p_busy_ignore_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !err_o && stage_i) |=> !stage_err_o);
endmodule

// File: tb/scl_pool_top_tb.sv
module scl_pool_top_tb;
  localparam int NU  = 8;
  localparam int NS  = 2;
  localparam int DW  = 14;
  localparam int UW  = 3;
  localparam int IDW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stage = 1'b0, rel = 1'b0, need = 1'b0, semi = 1'b0, ilace = 1'b0, commit = 1'b0;
  logic [UW-1:0] user = '0;
  logic [DW-1:0] sw = '0, sh = '0, dw = '0, dh = '0;
  logic stage_err, busy, done, err;
  logic [NU-1:0] gv;
  logic [NU*IDW-1:0] gid;
  logic [NS-1:0] in_use, mode;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  scl_pool_top #(.NUM_USERS(NU), .NUM_SCALERS(NS), .DW(DW), .VLIMIT_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stage_i(stage), .stage_user_i(user),
    .release_i(rel), .need_i(need), .semi_i(semi), .interlace_i(ilace),
    .src_w_i(sw), .src_h_i(sh), .dst_w_i(dw), .dst_h_i(dh), .commit_i(commit),
    .stage_err_o(stage_err), .busy_o(busy), .done_o(done), .err_o(err),
    .grant_vld_o(gv), .grant_id_o(gid), .in_use_o(in_use), .mode_o(mode)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int id_of(input int u);
    return int'(gid[u*IDW +: IDW]);
  endfunction

  task automatic do_stage(input int u, input int a, input int b, input int c, input int d,
                          input bit s, input bit n, input bit r, input bit il, output bit e);
    user = UW'(u); sw = DW'(a); sh = DW'(b); dw = DW'(c); dh = DW'(d);
    semi = s; need = n; rel = r; ilace = il; stage = 1'b1;
    @(negedge clk);
    stage = 1'b0; rel = 1'b0; need = 1'b0; semi = 1'b0; ilace = 1'b0;
    e = stage_err;
  endtask

  task automatic release_user(input int u);
    bit e;
    do_stage(u, 100, 100, 100, 100, 1'b0, 1'b0, 1'b1, 1'b0, e);
  endtask

  // returns 1 on done, 2 on error, 0 on timeout
  task automatic wait_outcome(output int res);
    res = 0;
    for (int n = 0; n < 200; n++) begin
      if (done || err) begin
        res = done ? 1 : 2;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    check("R13 pulse ends", int'(done | err), 0);
  endtask

  task automatic do_commit(output int res);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    wait_outcome(res);
  endtask

  task automatic t_reset();
    check("R1 grants", int'(gv), 0);
    check("R1 in_use", int'(in_use), 0);
    check("R1 mode", int'(mode), 0);
    check("R1 flags", int'({done, err, stage_err}), 0);
  endtask

  task automatic t_need();
    bit e; int r;
    do_stage(1, 100, 100, 100, 100, 1'b0, 1'b0, 1'b0, 1'b0, e);
    do_commit(r);
    check("R2 equal sizes done", r, 1);
    check("R2 equal sizes no grant", int'(gv[1]), 0);
    do_stage(1, 100, 100, 200, 200, 1'b0, 1'b0, 1'b0, 1'b0, e);
    do_commit(r);
    check("R2 differing sizes grant", int'(gv[1]), 1);
    check("R8 single on 0", id_of(1), 0);
    check("R8 hq mode", int'(mode), 1);
  endtask

  task automatic t_order();
    bit e; int r;
    do_stage(4, 200, 100, 100, 100, 1'b0, 1'b0, 1'b0, 1'b0, e);
    do_commit(r);
    check("R7 done", r, 1);
    check("R7 holder keeps 0", id_of(1), 0);
    check("R7 new user gets 1", id_of(4), 1);
    check("R8 two users dynamic", int'(mode), 0);
  endtask

  task automatic t_release_move();
    int r;
    release_user(1);
    check("R3 grant dropped", int'(gv[1]), 0);
    check("R3 scaler freed", int'(in_use), 2);
    do_commit(r);
    check("R8 moved to 0", id_of(4), 0);
    check("R8 in_use after move", int'(in_use), 1);
    check("R8 hq after move", int'(mode), 1);
  endtask

  task automatic t_range();
    bit e;
    do_stage(2, 7, 100, 100, 100, 1'b0, 1'b0, 1'b0, 1'b0, e);
    check("R4 src below 8", int'(e), 1);
    do_stage(2, 12, 20, 40, 40, 1'b1, 1'b0, 1'b0, 1'b0, e);
    check("R4 semi src below 16", int'(e), 1);
    do_stage(5, 4096, 100, 4097, 100, 1'b0, 1'b0, 1'b0, 1'b0, e);
    check("R4 dst above max", int'(e), 1);
    check("R4 no grant change", int'(gv), 8'h10);
    do_stage(2, 16, 16, 32, 32, 1'b1, 1'b0, 1'b0, 1'b0, e);
    check("R4 semi 16 accepted", int'(e), 0);
  endtask

  task automatic t_overcount();
    bit e; int r;
    do_stage(3, 100, 100, 150, 150, 1'b0, 1'b0, 1'b0, 1'b0, e);
    do_commit(r);
    check("R6 three users error", r, 2);
    check("R6 grants kept", int'(gv), 8'h10);
    check("R6 in_use kept", int'(in_use), 1);
  endtask

  task automatic t_interlace();
    bit e;
    do_stage(3, 100, 100, 150, 150, 1'b0, 1'b0, 1'b0, 1'b1, e);
    check("R5 interlaced rejected", int'(e), 1);
    do_stage(3, 100, 100, 100, 100, 1'b0, 1'b0, 1'b1, 1'b0, e);
    check("R5 release accepted", int'(e), 0);
  endtask

  task automatic t_vlimit();
    bit e; int r;
    do_commit(r);
    check("R7 lowest free", id_of(2), 1);
    check("R7 holder kept", id_of(4), 0);
    do_stage(2, 32, 64, 32, 32, 1'b0, 1'b0, 1'b0, 1'b0, e);
    do_commit(r);
    check("R10 vertical down on 1 fails", r, 2);
    check("R11 grant kept", id_of(2), 1);
    check("R11 in_use kept", int'(in_use), 3);
    release_user(2);
    do_stage(4, 100, 200, 100, 100, 1'b0, 1'b0, 1'b0, 1'b0, e);
    do_commit(r);
    check("R10 vertical down on 0 ok", r, 1);
  endtask

  task automatic t_ratio_rollback();
    bit e; int r;
    release_user(4);
    do_stage(1, 100, 100, 200, 100, 1'b0, 1'b0, 1'b0, 1'b0, e);
    do_stage(6, 300, 100, 100, 100, 1'b0, 1'b0, 1'b0, 1'b0, e);
    do_commit(r);
    check("R9 ratio 3 fails", r, 2);
    check("R11 earlier bind undone", int'(gv), 0);
    check("R11 in_use restored", int'(in_use), 0);
    do_stage(6, 299, 100, 100, 100, 1'b0, 1'b0, 1'b0, 1'b0, e);
    do_commit(r);
    check("R9 ratio below 3 ok", r, 1);
    check("R7 first user scaler 0", id_of(1), 0);
    check("R7 second user scaler 1", id_of(6), 1);
  endtask

  task automatic t_busy();
    int r;
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    user = 3'd1; rel = 1'b1; stage = 1'b1;
    @(negedge clk);
    stage = 1'b0; rel = 1'b0;
    wait_outcome(r);
    check("R12 commit done", r, 1);
    check("R12 release ignored", int'(gv[1]), 1);
  endtask

  task automatic t_explicit();
    bit e; int r;
    release_user(1);
    release_user(6);
    do_stage(0, 100, 100, 100, 100, 1'b0, 1'b1, 1'b0, 1'b0, e);
    do_commit(r);
    check("R2 explicit need grant", int'(gv), 1);
    check("R2 explicit need id", id_of(0), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_need();
    t_order();
    t_release_move();
    t_range();
    t_overcount();
    t_interlace();
    t_vlimit();
    t_ratio_rollback();
    t_busy();
    t_explicit();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule